// File: doc/BRIEF.md
# Nineteen-Bit Multicycle Harvard Processor Core

This block is a small processor core whose data words, registers and addresses are all 19 bits wide. It talks to two separate memories, one for instructions and one for data, each addressed in whole 19-bit words with no byte lanes. Every instruction is a fixed 32 bits wide, which leaves room for a complete 19-bit immediate beside a 5-bit opcode and two 4-bit register fields.

A four-phase sequencer drives the core: Reset while the reset input is high, then a repeating Fetch, Decode, Execute loop, so each instruction takes three cycles. Fetch latches the instruction word and steps the program counter. Decode reads the register operands and forms the effective operand `reg[rs] + imm`. Execute performs the operation, writes the register file, drives the data port, or redirects the program counter. Calls and returns use a small hardware stack of return addresses.

The memories live outside the block. The instruction read data and the data read data must be presented in the same cycle as their addresses.

Top module: `cpu19_core`

## Requirements
- R1: After reset is released the core spends one cycle in Reset, then cycles Fetch, Decode, Execute in that order and returns to Fetch after every Execute. `imem_re` is high exactly in Fetch cycles.
- R2: While `rst` is high, `imem_addr` is 0, `imem_re`, `dmem_we` and `dmem_re` are low, and all sixteen registers read as zero afterwards.
- R3: The instruction layout is opcode [31:27], rd [26:23], rs [22:19] and imm [18:0]. Register 0 always reads zero, and writes to it are discarded.
- R4: Each Fetch places the program counter on `imem_addr` and then advances it by one, modulo 2^19. 0x7FFFF steps to 0.
- R5: Let B = reg[rs] + imm, modulo 2^19. The opcode encodings are NOT=00000, AND=00001, OR=00010, XOR=00011, ADD=00100, SUB=00101, MUL=00110, DIV=00111, INC=01000 and DEC=01001. NOT, INC and DEC write ~B, B+1 and B-1 to rd. The binary operations write reg[rd] op B to rd. All results wrap modulo 2^19.
- R6: MUL keeps the low 19 bits of the product. DIV is an unsigned quotient, and division by zero yields 0x7FFFF.
- R7: JMP (01100) loads the program counter with imm. BEQ (01101) and BNE (01110) compare reg[rd] with reg[rs] and load imm only when they are equal or unequal, respectively. Otherwise execution continues at the next word.
- R8: CALL (01111) pushes the address after the call and jumps to imm. RET (10000) pops into the program counter. The stack holds 8 entries, and a push onto a full stack overwrites the oldest entry.
- R9: RET with an empty stack continues at the next word.
- R10: LD (10001) writes data word reg[rs]+imm into rd, with `dmem_re` high in its Execute cycle. ST (10010) writes reg[rd] to address reg[rs]+imm, with `dmem_we` high for exactly that one Execute cycle.
- R11: Opcodes 01010, 01011 and 10011 to 11111 change no register or memory and only advance the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 19 | Instruction word address (program counter) |
| imem_re | output | 1 | Instruction read strobe, high in Fetch |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 19 | Data word address |
| dmem_wdata | output | 19 | Store data |
| dmem_we | output | 1 | Data write enable, one cycle per store |
| dmem_re | output | 1 | Data read strobe, high in a load's Execute |
| dmem_rdata | input | 19 | Data word at `dmem_addr`, same cycle |

## Verification
The bench goes after the wrap points. An adder or counter sized wrongly would let 0x7FFFF+1 leak into bit 19, so the test includes ADD overflow, INC of all-ones, DEC of zero and a fetch from address 0x7FFFF. It recurses ten calls deep, which overflows the eight-entry return stack and then ends with a return on an empty stack. A design with a bad stack pointer or a bad empty check would return to the wrong address, which shows on `imem_addr` in the cycle that follows. Branches are exercised both taken and not taken, and a program counter that mishandles the not-taken case skips or repeats a fetch address. Divide-by-zero, writes to register 0 and undefined opcodes are each followed by a store, so a wrong result, a stray write or a stray register update appears on `dmem_wdata`.

// File: rtl/cpu19_pkg.sv
package cpu19_pkg;
  localparam int XLEN = 19;
  localparam int ILEN = 32;
  localparam int OPW  = 5;
  localparam int NREG = 16;
  localparam int RAW  = $clog2(NREG);

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [1:0] {
    PH_RESET  = 2'd0,
    PH_FETCH  = 2'd1,
    PH_DECODE = 2'd2,
    PH_EXEC   = 2'd3
  } phase_e;

  typedef struct packed {
    logic [OPW-1:0] op;
    logic [RAW-1:0] rd;
    logic [RAW-1:0] rs;
    word_t          imm;
  } instr_t;

  localparam logic [OPW-1:0] OP_NOT  = 5'b00000;
  localparam logic [OPW-1:0] OP_AND  = 5'b00001;
  localparam logic [OPW-1:0] OP_OR   = 5'b00010;
  localparam logic [OPW-1:0] OP_XOR  = 5'b00011;
  localparam logic [OPW-1:0] OP_ADD  = 5'b00100;
  localparam logic [OPW-1:0] OP_SUB  = 5'b00101;
  localparam logic [OPW-1:0] OP_MUL  = 5'b00110;
  localparam logic [OPW-1:0] OP_DIV  = 5'b00111;
  localparam logic [OPW-1:0] OP_INC  = 5'b01000;
  localparam logic [OPW-1:0] OP_DEC  = 5'b01001;
  localparam logic [OPW-1:0] OP_JMP  = 5'b01100;
  localparam logic [OPW-1:0] OP_BEQ  = 5'b01101;
  localparam logic [OPW-1:0] OP_BNE  = 5'b01110;
  localparam logic [OPW-1:0] OP_CALL = 5'b01111;
  localparam logic [OPW-1:0] OP_RET  = 5'b10000;
  localparam logic [OPW-1:0] OP_LD   = 5'b10001;
  localparam logic [OPW-1:0] OP_ST   = 5'b10010;

  // Opcodes that write an arithmetic/logic result into rd.
  function automatic logic op_is_alu(logic [OPW-1:0] op);
    return op <= OP_DEC;
  endfunction

  // Effective operand: base register plus immediate, wrapping at 2^19.
  function automatic word_t eff_operand(word_t base, word_t off);
    return base + off;
  endfunction

  function automatic word_t pc_step(word_t pc);
    return pc + 1'b1;
  endfunction

  // a = reg[rd], b = reg[rs] + imm
  function automatic word_t alu_calc(logic [OPW-1:0] op, word_t a, word_t b);
    word_t r;
    case (op)
      OP_NOT:  r = ~b;
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_ADD:  r = a + b;
      OP_SUB:  r = a - b;
      OP_MUL:  r = a * b;
      OP_DIV:  r = (b == '0) ? '1 : a / b;
      OP_INC:  r = b + 1'b1;
      OP_DEC:  r = b - 1'b1;
      default: r = a;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cpu19_seq.sv
module cpu19_seq
  import cpu19_pkg::*;
(
  input  logic clk,
  input  logic rst,
  output logic in_fetch,
  output logic in_decode,
  output logic in_exec
);
  phase_e phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_RESET;
    end else begin
      case (phase_q)
        PH_RESET:  phase_q <= PH_FETCH;
        PH_FETCH:  phase_q <= PH_DECODE;
        PH_DECODE: phase_q <= PH_EXEC;
        default:   phase_q <= PH_FETCH;
      endcase
    end
  end

  assign in_fetch  = (phase_q == PH_FETCH);
  assign in_decode = (phase_q == PH_DECODE);
  assign in_exec   = (phase_q == PH_EXEC);

  assert_exec_to_fetch_R1: assert property (@(posedge clk) disable iff (rst)
    in_exec |=> in_fetch);
  assert_fetch_to_decode_R1: assert property (@(posedge clk) disable iff (rst)
    in_fetch |=> in_decode);
endmodule

// File: rtl/cpu19_regfile.sv
module cpu19_regfile #(
  parameter int N = 16,
  parameter int W = 19,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [N];
  logic         wr_hit;

  assign wr_hit = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (wr_hit) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];

  assert_zero_reg_R3: assert property (@(posedge clk) disable iff (rst)
    (ra_a == '0) |-> (rd_a == '0));
endmodule

// File: rtl/cpu19_retstack.sv
module cpu19_retstack #(
  parameter int DEPTH = 8,
  parameter int W = 19,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_val,
  output logic [W-1:0] top_val,
  output logic         nonempty
);
  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] ptr_q, ptr_inc, ptr_dec;
  logic [CW-1:0] cnt_q;
  logic          full;

  assign ptr_inc  = (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  assign ptr_dec  = (ptr_q == '0) ? PW'(DEPTH - 1) : ptr_q - 1'b1;
  assign full     = (cnt_q == CW'(DEPTH));
  assign nonempty = (cnt_q != '0);
  assign top_val  = slots[ptr_dec];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (push) begin
      ptr_q <= ptr_inc;
      if (!full) cnt_q <= cnt_q + 1'b1;
    end else if (pop && nonempty) begin
      ptr_q <= ptr_dec;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[ptr_q] <= push_val;
  end

  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  assert_full_saturates_R8: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> full);
endmodule

// File: rtl/cpu19_core.sv
module cpu19_core
  import cpu19_pkg::*;
#(
  parameter int RSTACK_DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  output logic            imem_re,
  input  logic [ILEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  output logic            dmem_re,
  input  logic [XLEN-1:0] dmem_rdata
);
  logic   in_fetch, in_decode, in_exec;
  word_t  pc_q, pc_d;
  instr_t ir_q;
  word_t  opa_q, opb_q, opc_q;
  word_t  rf_a, rf_b, rf_wd;
  logic   rf_we;
  logic   rs_push, rs_pop, rs_nonempty;
  word_t  rs_top;
  logic   is_alu, is_ld, is_st, take_jump;
  logic   ret_empty_ev;

  cpu19_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .in_fetch (in_fetch),
    .in_decode(in_decode),
    .in_exec  (in_exec)
  );

  cpu19_regfile #(.N(NREG), .W(XLEN)) u_rf (
    .clk (clk),
    .rst (rst),
    .ra_a(ir_q.rd),
    .ra_b(ir_q.rs),
    .rd_a(rf_a),
    .rd_b(rf_b),
    .we  (rf_we),
    .wa  (ir_q.rd),
    .wd  (rf_wd)
  );

  cpu19_retstack #(.DEPTH(RSTACK_DEPTH), .W(XLEN)) u_rs (
    .clk     (clk),
    .rst     (rst),
    .push    (rs_push),
    .pop     (rs_pop),
    .push_val(pc_q),
    .top_val (rs_top),
    .nonempty(rs_nonempty)
  );

  assign is_alu = op_is_alu(ir_q.op);
  assign is_ld  = (ir_q.op == OP_LD);
  assign is_st  = (ir_q.op == OP_ST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      opa_q <= '0;
      opb_q <= '0;
      opc_q <= '0;
    end else begin
      pc_q <= pc_d;
      if (in_fetch) ir_q <= instr_t'(imem_rdata);
      if (in_decode) begin
        opa_q <= rf_a;
        opc_q <= rf_b;
        opb_q <= eff_operand(rf_b, ir_q.imm);
      end
    end
  end

  always_comb begin
    pc_d      = pc_q;
    rs_push   = 1'b0;
    rs_pop    = 1'b0;
    take_jump = 1'b0;
    if (in_fetch) begin
      pc_d = pc_step(pc_q);
    end else if (in_exec) begin
      case (ir_q.op)
        OP_JMP:  take_jump = 1'b1;
        OP_BEQ:  take_jump = (opa_q == opc_q);
        OP_BNE:  take_jump = (opa_q != opc_q);
        OP_CALL: begin
          take_jump = 1'b1;
          rs_push   = 1'b1;
        end
        OP_RET: begin
          rs_pop = rs_nonempty;
          if (rs_nonempty) pc_d = rs_top;
        end
        default: ;
      endcase
      if (take_jump) pc_d = ir_q.imm;
    end
  end

  assign ret_empty_ev = in_exec && (ir_q.op == OP_RET) && !rs_nonempty;

  assign rf_we = in_exec && (is_alu || is_ld);
  assign rf_wd = is_ld ? dmem_rdata : alu_calc(ir_q.op, opa_q, opb_q);

  assign imem_addr  = pc_q;
  assign imem_re    = in_fetch;
  assign dmem_addr  = opb_q;
  assign dmem_wdata = opa_q;
  assign dmem_we    = in_exec && is_st;
  assign dmem_re    = in_exec && is_ld;

  assert_fetch_once_R1: assert property (@(posedge clk) disable iff (rst)
    imem_re |=> !imem_re);
  assert_pc_step_R4: assert property (@(posedge clk) disable iff (rst)
    in_fetch |=> (pc_q == $past(pc_q) + 1'b1));
  assert_ret_empty_hold_R9: assert property (@(posedge clk) disable iff (rst)
    ret_empty_ev |=> (pc_q == $past(pc_q)));
  assert_we_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    dmem_we |=> (!dmem_we && imem_re));
  assert_no_rw_overlap_R10: assert property (@(posedge clk) disable iff (rst)
    !(dmem_we && dmem_re));
endmodule

// File: tb/tb_cpu19_core.sv
module tb_cpu19_core;
  localparam int M   = 1 << 19;
  localparam int IMN = 128;
  localparam int DMN = 64;
  localparam int RUN = 1200;

  logic        clk = 1'b0;
  logic        rst;
  logic [18:0] imem_addr, dmem_addr, dmem_wdata, dmem_rdata;
  logic [31:0] imem_rdata;
  logic        imem_re, dmem_we, dmem_re;

  logic [31:0] imem [IMN];
  string       itag [IMN];
  logic [18:0] dmem [DMN];
  int          ref_dmem [DMN];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  cpu19_core dut (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_re(imem_re), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_re(dmem_re), .dmem_rdata(dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[6:0]];
  assign dmem_rdata = dmem[dmem_addr[5:0]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[5:0]] <= dmem_wdata;

  // ---------------- reference model state ----------------
  int mstate;          // 0 reset, 1 fetch, 2 decode, 3 execute
  int mpc;
  int mia;             // instruction memory slot of the current instruction
  logic [31:0] mir;
  int mreg [16];
  int stk [$];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int ref_alu(int op, int a, int b);
    case (op)
      0: return M - 1 - b;
      1: return a & b;
      2: return a | b;
      3: return a ^ b;
      4: return (a + b) % M;
      5: return (a - b + M) % M;
      6: return int'((longint'(a) * longint'(b)) % longint'(M));
      7: return (b == 0) ? M - 1 : a / b;
      8: return (b + 1) % M;
      default: return (b + M - 1) % M;
    endcase
  endfunction

  task automatic model_step(input logic r);
    int op, rd, rs, imm, a, c, b;
    if (r) begin
      mstate = 0; mpc = 0; mir = '0; mia = 0;
      foreach (mreg[i]) mreg[i] = 0;
      stk.delete();
      return;
    end
    op = int'(mir[31:27]); rd = int'(mir[26:23]);
    rs = int'(mir[22:19]); imm = int'(mir[18:0]);
    case (mstate)
      0: mstate = 1;
      1: begin
        mia = mpc % IMN;
        mir = imem[mia];
        mpc = (mpc + 1) % M;
        mstate = 2;
      end
      2: mstate = 3;
      default: begin
        a = mreg[rd]; c = mreg[rs]; b = (c + imm) % M;
        if (op <= 9) begin
          if (rd != 0) mreg[rd] = ref_alu(op, a, b);
        end else if (op == 12) mpc = imm;
        else if (op == 13) begin if (a == c) mpc = imm; end
        else if (op == 14) begin if (a != c) mpc = imm; end
        else if (op == 15) begin
          stk.push_back(mpc);
          if (stk.size() > 8) void'(stk.pop_front());
          mpc = imm;
        end else if (op == 16) begin
          if (stk.size() > 0) mpc = stk.pop_back();
        end else if (op == 17) begin
          if (rd != 0) mreg[rd] = ref_dmem[b % DMN];
        end else if (op == 18) ref_dmem[b % DMN] = a;
        mstate = 1;
      end
    endcase
  endtask

  task automatic compare(input int cyc);
    int op, rd, rs, imm;
    op = int'(mir[31:27]); rd = int'(mir[26:23]);
    rs = int'(mir[22:19]); imm = int'(mir[18:0]);
    if (mstate == 0 && cyc < 4) begin
      chk("R2 reset imem_addr", int'(imem_addr), 0);
      chk("R2 reset dmem_we", int'(dmem_we), 0);
      chk("R2 reset dmem_re", int'(dmem_re), 0);
    end
    chk("R1 fetch strobe", int'(imem_re), int'(mstate == 1));
    chk("R4/R7/R8/R9 program counter", int'(imem_addr), mpc);
    if (mstate == 3 && op == 18) begin
      chk({itag[mia], " store enable"}, int'(dmem_we), 1);
      chk({itag[mia], " store address"}, int'(dmem_addr), (mreg[rs] + imm) % M);
      chk({itag[mia], " store data"}, int'(dmem_wdata), mreg[rd]);
    end else begin
      chk("R10 no stray write", int'(dmem_we), 0);
    end
    chk("R10 load strobe", int'(dmem_re), int'(mstate == 3 && op == 17));
  endtask

  // ---------------- program construction ----------------
  int pa;

  function automatic logic [31:0] enc(int op, int rd, int rs, int imm);
    logic [31:0] w;
    w[31:27] = 5'(op); w[26:23] = 4'(rd); w[22:19] = 4'(rs); w[18:0] = 19'(imm);
    return w;
  endfunction

  task automatic put(input int at, input int op, input int rd, input int rs,
                     input int imm, input string tag);
    imem[at] = enc(op, rd, rs, imm);
    itag[at] = tag;
  endtask

  task automatic emit(input int op, input int rd, input int rs, input int imm,
                      input string tag);
    put(pa, op, rd, rs, imm, tag);
    pa++;
  endtask

  task automatic build_program();
    int cont_deep, cont_wrap;
    foreach (imem[i]) begin imem[i] = '0; itag[i] = "R5"; end
    foreach (dmem[i]) begin dmem[i] = '0; ref_dmem[i] = 0; end
    dmem[40] = 19'h5A5A5; ref_dmem[40] = 'h5A5A5;
    pa = 0;
    emit(18, 13, 0, 1, "R2");             // untouched register reads zero
    emit(4, 1, 0, 5, "R5");               // r1 = 5
    emit(4, 2, 0, 12, "R5");              // r2 = 12
    emit(4, 3, 0, 'h7FFFF, "R5");         // r3 = all ones
    emit(4, 5, 0, 'h0F0F0, "R5");
    emit(1, 5, 2, 3, "R5");               // AND with r2+3
    emit(18, 5, 0, 2, "R5");
    emit(2, 5, 1, 0, "R5");               // OR
    emit(18, 5, 0, 3, "R5");
    emit(3, 5, 3, 0, "R5");               // XOR with all ones
    emit(18, 5, 0, 4, "R5");
    emit(0, 6, 1, 0, "R5");               // NOT
    emit(18, 6, 0, 5, "R5");
    emit(4, 7, 0, 'h7FFFF, "R5");
    emit(4, 7, 1, 0, "R5");               // ADD overflow wraps
    emit(18, 7, 0, 6, "R5");
    emit(5, 8, 1, 0, "R5");               // SUB below zero
    emit(18, 8, 0, 7, "R5");
    emit(4, 9, 0, 'h1234, "R6");
    emit(6, 9, 0, 'h1F1, "R6");           // MUL truncated
    emit(18, 9, 0, 8, "R6");
    emit(4, 10, 0, 100, "R6");
    emit(7, 10, 1, 2, "R6");              // DIV 100/7
    emit(18, 10, 0, 9, "R6");
    emit(4, 11, 0, 9, "R6");
    emit(7, 11, 0, 0, "R6");              // DIV by zero
    emit(18, 11, 0, 10, "R6");
    emit(8, 12, 3, 0, "R5");              // INC wraps to zero
    emit(18, 12, 0, 11, "R5");
    emit(9, 12, 0, 0, "R5");              // DEC of zero
    emit(18, 12, 0, 12, "R5");
    emit(4, 0, 0, 77, "R3");              // write to r0 discarded
    emit(18, 0, 0, 13, "R3");
    emit(4, 14, 0, 0, "R3");              // r14 = r14 + r0 + 0
    emit(18, 14, 0, 14, "R3");
    // R7 branches
    emit(13, 1, 1, pa + 2, "R7");         // BEQ taken
    emit(4, 9, 0, 1, "R7");               // skipped
    emit(14, 1, 1, 0, "R7");              // BNE not taken
    emit(13, 1, 2, 0, "R7");              // BEQ not taken
    emit(14, 1, 2, pa + 2, "R7");         // BNE taken
    emit(4, 9, 0, 1, "R7");               // skipped
    emit(18, 9, 0, 15, "R7");
    // R8 nested call
    emit(1, 15, 0, 0, "R8");
    emit(15, 0, 0, 102, "R8");
    emit(18, 15, 0, 16, "R8");
    // R8/R9 recursion deeper than the stack
    emit(1, 15, 0, 0, "R8");
    emit(4, 14, 0, 10, "R8");
    emit(15, 0, 0, 104, "R8");
    cont_deep = pa;
    emit(18, 15, 0, 17, "R8");
    emit(16, 0, 0, 0, "R9");              // RET on empty stack
    emit(18, 15, 0, 18, "R9");
    // R10 load/store
    emit(17, 4, 2, 28, "R10");            // LD from 12+28 = 40
    emit(18, 4, 0, 19, "R10");
    emit(18, 1, 2, 30, "R10");            // ST to 42
    emit(17, 5, 0, 42, "R10");
    emit(18, 5, 0, 20, "R10");
    // R11 undefined opcodes
    emit(10, 1, 0, 3, "R11");
    emit(11, 1, 0, 3, "R11");
    emit(19, 1, 0, 3, "R11");
    emit(31, 1, 0, 3, "R11");
    emit(18, 1, 0, 21, "R11");
    // R4 program counter wrap
    emit(12, 0, 0, 'h7FFFF, "R4");
    cont_wrap = pa;
    emit(18, 2, 0, 22, "R4");
    emit(12, 0, 0, pa, "R4");             // halt loop
    // subroutines
    put(100, 8, 15, 15, 0, "R8");         // inc counter
    put(101, 16, 0, 0, 0, "R8");
    put(102, 15, 0, 0, 100, "R8");        // nested call
    put(103, 16, 0, 0, 0, "R8");
    put(104, 8, 15, 15, 0, "R8");         // recursive body
    put(105, 13, 15, 14, 107, "R8");
    put(106, 15, 0, 0, 104, "R8");
    put(107, 16, 0, 0, 0, "R8");
    put(108, 12, 0, 0, cont_deep, "R9");  // reached after empty return
    put(127, 12, 0, 0, cont_wrap, "R4");  // word at 0x7FFFF (mod 128)
  endtask

  initial begin
    rst = 1'b1;
    build_program();
    model_step(1'b1);
    for (int cyc = 0; cyc < RUN; cyc++) begin
      @(negedge clk);
      compare(cyc);
      if (cyc == 3) rst = 1'b0;
      model_step(rst);
    end
    for (int i = 1; i < 23; i++)
      chk("R10 final data memory", int'(dmem[i]), ref_dmem[i]);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule